// File: doc/BRIEF.md
# Fall-Through Handshake FIFO

This block is a first-in first-out buffer built as a chain of word cells instead of a RAM with read and write pointers. Each cell holds one data word and a valid flag. A word placed in the entry cell moves on its own toward the output end. On each clock it advances into the next cell if that cell is empty. As a result, words pile up at the output end and empty cells drift back toward the entry cell.

Both sides use level-driven shift strobes that may arrive asynchronously. Each strobe passes through a two-flop synchronizer before edge detection.

On the write side, the producer watches `in_ready`. While it is high, the producer places a word on `din` and raises `shift_in`. The word is captured and `in_ready` drops. The word stays parked in the entry cell until `shift_in` falls. Then it starts to fall through, and `in_ready` comes back once the entry cell has emptied.

On the read side, the consumer watches `out_ready`. While it is high, the consumer raises `shift_out` to take the word on `dout`. `out_ready` drops while the word stays on `dout`. When `shift_out` falls, the word is released and the next word, if any, moves into the output stage.

Back-pressure rules:
- A producer that raises `shift_in` while `in_ready` is low is ignored.
- A consumer that raises `shift_out` while `out_ready` is low is ignored.
- `din` must be stable from the rise of `shift_in` until `in_ready` falls.

Top module: `fallthru_fifo`

## Requirements
- R1: While `mrst_n` is low and right after it is released, every cell is empty: `in_ready` is 1, `out_ready` is 0 and `dout` is 0.
- R2: A rise of `shift_in` while `in_ready` is 1 captures `din` into the entry cell, and `in_ready` falls within 10 clocks.
- R3: `in_ready` stays 0 for as long as `shift_in` stays high after a capture.
- R4: After `shift_in` falls, `in_ready` returns to 1 if the FIFO holds fewer than DEPTH words. When the write fills the FIFO to DEPTH words, `in_ready` stays 0.
- R5: A word advances at most one cell per clock. For a word written into an empty FIFO, `out_ready` rises exactly DEPTH-2 clocks after `in_ready` returns to 1.
- R6: A rise of `shift_out` while `out_ready` is 1 makes `out_ready` fall within 10 clocks. `dout` holds its word while `shift_out` stays high, and `dout` does not change in the clock after any clock in which `out_ready` is 1.
- R7: After `shift_out` falls, the next stored word is shown on `dout` with `out_ready` high again. Words leave in the order they were written.
- R8: Once the FIFO is empty, `out_ready` stays 0 and `dout` keeps the last word read.
- R9: A rise of `shift_in` while `in_ready` is 0 stores nothing. A full FIFO written once more still yields exactly DEPTH words.
- R10: A rise of `shift_out` while `out_ready` is 0 is ignored. A word that arrives while `shift_out` is still high from that rise is neither taken nor released when `shift_out` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the strobes and advances the cells |
| mrst_n | input | 1 | Master reset, active low, asynchronous; empties all cells |
| shift_in | input | 1 | Write strobe level, asynchronous to `clk` |
| din | input | WIDTH | Word to write |
| in_ready | output | 1 | High when the entry cell is empty and a write is accepted |
| shift_out | input | 1 | Read strobe level, asynchronous to `clk` |
| out_ready | output | 1 | High when the output stage holds a word not yet taken |
| dout | output | WIDTH | Word in the output stage; holds its last value when empty |

## Verification
A valid flag that is lost or wrongly set inside the chain shows up at the ports as a missing or duplicated word during a full drain. A mis-ordered transfer shows up as a wrong value at the first read it touches. Because cells pack toward the output, a stuck entry cell appears as `in_ready` failing to return within a few clocks of `shift_in` falling. The exact DEPTH-2 latency check on an empty FIFO exposes any cell that skips or stalls a word.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
  // Edge events decoded from a synchronized strobe level.
  typedef struct packed {
    logic rise;
    logic fall;
  } strobe_ev_t;
endpackage

// File: rtl/ftf_strobe_sync.sv
module ftf_strobe_sync
  import ftf_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe_async,
  output strobe_ev_t ev
);
  localparam int HIST = STAGES + 1;

  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value.
  logic [HIST-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[HIST-2:0], strobe_async};
  end

  assign ev.rise = sh[STAGES-1] & ~sh[STAGES];
  assign ev.fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/ftf_wr_ctrl.sv
module ftf_wr_ctrl
  import ftf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_ev_t ev,
  input  logic       first_full,
  output logic       load,
  output logic       hold
);
  // A rise is honoured only when the entry cell is free.
  assign load = ev.rise & ~first_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold <= 1'b0;
    else if (load)    hold <= 1'b1;
    else if (ev.fall) hold <= 1'b0;
  end

  p_park_keeps_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> first_full);
  p_ignored_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rise && first_full && !hold) |=> !hold);
endmodule

// File: rtl/ftf_rd_ctrl.sv
module ftf_rd_ctrl
  import ftf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_ev_t ev,
  input  logic       last_full,
  output logic       pop,
  output logic       out_ready
);
  logic taken;
  logic take;

  assign take      = ev.rise & last_full & ~taken;
  assign pop       = ev.fall & taken;
  assign out_ready = last_full & ~taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    taken <= 1'b0;
    else if (take) taken <= 1'b1;
    else if (pop)  taken <= 1'b0;
  end

  p_taken_word_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> last_full);
  p_rise_on_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.rise && !last_full && !taken) |=> !taken);
endmodule

// File: rtl/ftf_cell_chain.sv
module ftf_cell_chain #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             hold_first,
  input  logic             pop,
  output logic             first_full,
  output logic             last_full,
  output logic [WIDTH-1:0] last_data
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] adv;   // word leaves cell i this clock
  logic [DEPTH-1:0] arr;   // word enters cell i this clock
  logic [WIDTH-1:0] dat [DEPTH];
  logic [WIDTH-1:0] src [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    if (gi == 0) begin : g_entry
      assign arr[gi] = load;
      assign src[gi] = load_data;
    end else begin : g_inner
      assign arr[gi] = adv[gi-1];
      assign src[gi] = dat[gi-1];
    end
    if (gi == LAST) begin : g_out
      assign adv[gi] = pop;
    end else if (gi == 0) begin : g_park
      assign adv[gi] = vld[gi] & ~vld[gi+1] & ~hold_first;
    end else begin : g_flow
      assign adv[gi] = vld[gi] & ~vld[gi+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) dat[i] <= '0;
    end else begin
      vld <= (vld & ~adv) | arr;
      for (int i = 0; i < DEPTH; i++) begin
        if (arr[i]) dat[i] <= src[i];
      end
    end
  end

  assign first_full = vld[0];
  assign last_full  = vld[LAST];
  assign last_data  = dat[LAST];

  p_load_into_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !vld[0]);
  p_pop_needs_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> vld[LAST]);
  p_only_writes_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld) > $past($countones(vld))) |-> $past(load));
endmodule

// File: rtl/fallthru_fifo.sv
module fallthru_fifo
  import ftf_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  output logic [WIDTH-1:0] dout
);
  strobe_ev_t wr_ev, rd_ev;
  logic load, hold, pop, first_full, last_full;

  ftf_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(mrst_n), .strobe_async(shift_in), .ev(wr_ev));

  ftf_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(mrst_n), .strobe_async(shift_out), .ev(rd_ev));

  ftf_wr_ctrl u_wr (
    .clk(clk), .rst_n(mrst_n), .ev(wr_ev), .first_full(first_full),
    .load(load), .hold(hold));

  ftf_rd_ctrl u_rd (
    .clk(clk), .rst_n(mrst_n), .ev(rd_ev), .last_full(last_full),
    .pop(pop), .out_ready(out_ready));

  ftf_cell_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst_n(mrst_n), .load(load), .load_data(din),
    .hold_first(hold), .pop(pop), .first_full(first_full),
    .last_full(last_full), .last_data(dout));

  assign in_ready = ~first_full;

  p_dout_steady_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    out_ready |=> $stable(dout));
  p_reset_empty_r1: assert property (@(posedge clk)
    !mrst_n |-> (in_ready && !out_ready));
endmodule

// File: tb/sim_fallthru_fifo.sv
module sim_fallthru_fifo;
  localparam int W = 4;
  localparam int D = 64;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic mrst_n = 1'b0;
  logic shift_in = 1'b0;
  logic shift_out = 1'b0;
  logic [W-1:0] din = '0;
  logic in_ready, out_ready;
  logic [W-1:0] dout;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fallthru_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .mrst_n(mrst_n), .shift_in(shift_in), .din(din),
    .in_ready(in_ready), .shift_out(shift_out), .out_ready(out_ready),
    .dout(dout));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k);
    return W'((k * 7 + 3) % 16);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc >= WDOG && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic write_word(input logic [W-1:0] v, input bit room);
    int n;
    din = v;
    shift_in = 1'b1;
    n = 0;
    while (in_ready && n < 10) begin @(negedge clk); n++; end
    check(!in_ready, "R2 capture drops in_ready", in_ready, 0);
    repeat (3) begin
      @(negedge clk);
      check(!in_ready, "R3 in_ready low while shift_in high", in_ready, 0);
    end
    shift_in = 1'b0;
    if (room) begin
      n = 0;
      while (!in_ready && n < 100) begin @(negedge clk); n++; end
      check(in_ready, "R4 in_ready returns", in_ready, 1);
    end else begin
      repeat (20) @(negedge clk);
      check(!in_ready, "R4 full keeps in_ready low", in_ready, 0);
    end
  endtask

  task automatic read_word(input logic [W-1:0] exp);
    int n;
    n = 0;
    while (!out_ready && n < 200) begin @(negedge clk); n++; end
    check(out_ready, "R7 next word presented", out_ready, 1);
    check(dout == exp, "R7 word order", dout, exp);
    shift_out = 1'b1;
    n = 0;
    while (out_ready && n < 10) begin @(negedge clk); n++; end
    check(!out_ready, "R6 take drops out_ready", out_ready, 0);
    repeat (3) begin
      @(negedge clk);
      check(dout == exp, "R6 dout held while shift_out high", dout, exp);
    end
    shift_out = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(in_ready, "R1 in_ready in reset", in_ready, 1);
    check(!out_ready, "R1 out_ready in reset", out_ready, 0);
    mrst_n = 1'b1;
    @(negedge clk);
    check(in_ready, "R1 in_ready after reset", in_ready, 1);
    check(!out_ready, "R1 out_ready after reset", out_ready, 0);
    check(dout == 0, "R1 dout after reset", dout, 0);
  endtask

  task automatic t_latency();
    int n;
    write_word(4'hA, 1'b1);
    n = 0;
    while (!out_ready && n < 200) begin @(negedge clk); n++; end
    check(n == D - 2, "R5 fall-through latency", n, D - 2);
    read_word(4'hA);
    repeat (50) begin
      @(negedge clk);
      check(!out_ready, "R8 empty keeps out_ready low", out_ready, 0);
    end
    check(dout == 4'hA, "R8 dout keeps last word", dout, 4'hA);
  endtask

  task automatic t_early_shift_out();
    int n;
    shift_out = 1'b1;
    repeat (10) @(negedge clk);
    write_word(4'h5, 1'b1);
    n = 0;
    while (!out_ready && n < 200) begin @(negedge clk); n++; end
    check(out_ready, "R10 word arrives under early shift_out", out_ready, 1);
    repeat (5) begin
      @(negedge clk);
      check(out_ready, "R10 early rise not taken", out_ready, 1);
    end
    shift_out = 1'b0;
    repeat (8) @(negedge clk);
    check(out_ready, "R10 fall without take keeps word", out_ready, 1);
    check(dout == 4'h5, "R10 word intact", dout, 4'h5);
    read_word(4'h5);
  endtask

  task automatic t_fill_drain();
    for (int k = 0; k < D; k++) write_word(pat(k), k != D - 1);
    din = 4'hF;
    shift_in = 1'b1;
    repeat (10) @(negedge clk);
    check(!in_ready, "R9 write into full ignored", in_ready, 0);
    shift_in = 1'b0;
    repeat (10) @(negedge clk);
    for (int k = 0; k < D; k++) read_word(pat(k));
    repeat (100) @(negedge clk);
    check(!out_ready, "R9 no extra word after drain", out_ready, 0);
    check(dout == pat(D - 1), "R8 dout keeps last after drain", dout, pat(D - 1));
    check(in_ready, "R4 room again after drain", in_ready, 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_early_shift_out();
    t_fill_drain();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule